// File: doc/BRIEF.md
# Four-Bank Page Read Sequencer

This block is the device-side command interpreter of a byte-wide flash read path with four banks. A host drives an 8-bit bus together with a command strobe qualifier (`cle`), an address qualifier (`ale`), an active-low write strobe (`we_n`) and an active-low read strobe (`re_n`). All of these are sampled on the block clock. A byte is taken on each rising edge of `we_n`.

The host first queues a page for one or more banks, in any bank order. It then issues a single start command. The block reports busy on `rdy` while it copies every queued page from a small behavioural array into that bank's page register. After the copy, the host names a bank and a start column, and receives that register's bytes one per `re_n` pulse. It may switch banks and re-read as often as it likes without another copy. The array is loaded through a separate preload port.

Top module: `mbank_read_seq`

## Requirements
- R1: After reset `rdy` is 1, `io_oe` is 0 and `io_out` is 0.
- R2: A byte is taken on a rising edge of `we_n`. It is a command when `cle`=1 and `ale`=0, and an address when `ale`=1 and `cle`=0. Command 00h must be followed by four address bytes: A1 carries the page in bits [PAGE_W-1:0] and A2 carries the bank in bits [1:0]. A0 and A3 play no part in page selection. The four bytes queue that page for that bank.
- R3: Command 31h with at least one bank queued makes `rdy` fall in the clock after the strobe edge is seen. `rdy` then stays 0 for exactly T_R clock cycles.
- R4: When the transfer ends, each queued bank's page register holds the array bytes of its queued page, and the queue is empty.
- R5: If the same bank is queued twice before 31h, the later page is the one transferred.
- R6: A bank that was not queued before a 31h keeps its earlier register contents.
- R7: Command 06h, then four address bytes, then command E0h selects a bank and a start column for output. A0 carries the column in bits [COL_W-1:0] and A2 carries the bank in bits [1:0]. While `re_n` is low, `io_oe` is 1 and `io_out` shows the byte at the current column.
- R8: Each rising edge of `re_n` during output advances the column by one. The column wraps from 2**COL_W-1 to 0.
- R9: Selection and read-out can be repeated for any bank, any number of times, with no new transfer. Each read returns the same register bytes.
- R10: The following are ignored: an E0h without a completed 06h selection, any strobe while `rdy` is 0, and a 31h with no bank queued (`rdy` stays 1).
- R11: A command arriving before all four address bytes of a selection discards the partial selection, and the block returns to idle.
- R12: If a command strobe and a `re_n` rising edge are seen in the same cycle, the command is taken and output stops (`io_oe` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cle | input | 1 | Command qualifier |
| ale | input | 1 | Address qualifier |
| we_n | input | 1 | Write strobe, byte taken on its rising edge |
| re_n | input | 1 | Read strobe, low presents a byte, rising edge advances |
| io_in | input | 8 | Host-to-block byte |
| io_out | output | 8 | Block-to-host byte |
| io_oe | output | 1 | High while the block drives a read byte |
| rdy | output | 1 | 1 = ready, 0 = transfer in progress |
| pre_we | input | 1 | Array preload write enable |
| pre_bank | input | BANK_W | Preload bank |
| pre_page | input | PAGE_W | Preload page |
| pre_col | input | COL_W | Preload column |
| pre_data | input | 8 | Preload byte |

## Verification
Two events can land in the same sampled cycle: a write strobe edge and a read strobe edge. While bytes are streaming, the bench lowers both strobes together with a 00h command and raises them together. It then checks that no byte is presented on the next read pulse. It also finishes that page selection and confirms, through a full transfer and read-back, that the command took effect. A second overlap, a write strobe landing inside a busy transfer, is judged the same way: the queue must come out empty and the register must hold the page queued before the start.

// File: rtl/mbr_pkg.sv
`timescale 1ns/1ps
package mbr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PGSEL,
        ST_RDSEL,
        ST_RDARM,
        ST_STREAM,
        ST_XFER
    } seq_st_e;

    localparam logic [7:0] OP_PAGE  = 8'h00;
    localparam logic [7:0] OP_START = 8'h31;
    localparam logic [7:0] OP_PICK  = 8'h06;
    localparam logic [7:0] OP_GO    = 8'hE0;
endpackage

// File: rtl/mbr_strobe.sv
`timescale 1ns/1ps
module mbr_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_n,
    output logic rise
);
    logic lvl_d, lvl_q;

    always_comb lvl_d = strb_n;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b1;
        else        lvl_q <= lvl_d;
    end

    assign rise = strb_n & ~lvl_q;
endmodule

// File: rtl/mbr_array.sv
`timescale 1ns/1ps
module mbr_array #(
    parameter int BANK_W = 2,
    parameter int PAGE_W = 2,
    parameter int COL_W  = 3
) (
    input  logic                           clk,
    input  logic                           pre_we,
    input  logic [BANK_W-1:0]              pre_bank,
    input  logic [PAGE_W-1:0]              pre_page,
    input  logic [COL_W-1:0]               pre_col,
    input  logic [7:0]                     pre_data,
    input  logic [(2**BANK_W)*PAGE_W-1:0]  sel_page,
    output logic [(2**BANK_W)*(2**COL_W)*8-1:0] rows
);
    localparam int NB    = 2**BANK_W;
    localparam int COLS  = 2**COL_W;
    localparam int AW    = BANK_W + PAGE_W + COL_W;
    localparam int DEPTH = 2**AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (pre_we) mem_q[{pre_bank, pre_page, pre_col}] <= pre_data;
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic [BANK_W-1:0] BI = BANK_W'(b);
        logic [PAGE_W-1:0] pg;
        assign pg = sel_page[b*PAGE_W +: PAGE_W];
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam logic [COL_W-1:0] CI = COL_W'(c);
            assign rows[(b*COLS + c)*8 +: 8] = mem_q[{BI, pg, CI}];
        end
    end
endmodule

// File: rtl/mbr_bank_regs.sv
`timescale 1ns/1ps
module mbr_bank_regs #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [(2**BANK_W)-1:0]              load,
    input  logic [(2**BANK_W)*(2**COL_W)*8-1:0] rows,
    input  logic [BANK_W-1:0]                   rd_bank,
    input  logic [COL_W-1:0]                    rd_col,
    output logic [7:0]                          rd_byte
);
    localparam int NB   = 2**BANK_W;
    localparam int COLS = 2**COL_W;
    localparam int ROWW = COLS*8;

    logic [ROWW-1:0] page_view [NB];

    for (genvar b = 0; b < NB; b++) begin : g_reg
        logic [ROWW-1:0] page_d, page_q;
        always_comb page_d = load[b] ? rows[b*ROWW +: ROWW] : page_q;
        always_ff @(posedge clk) begin
            if (!rst_n) page_q <= '0;
            else        page_q <= page_d;
        end
        assign page_view[b] = page_q;
    end

    logic [ROWW-1:0] cur_row;
    assign cur_row = page_view[rd_bank];
    assign rd_byte = cur_row[{rd_col, 3'b000} +: 8];
endmodule

// File: rtl/mbank_read_seq.sv
`timescale 1ns/1ps
module mbank_read_seq
    import mbr_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int PAGE_W = 2,
    parameter int COL_W  = 3,
    parameter int T_R    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cle,
    input  logic              ale,
    input  logic              we_n,
    input  logic              re_n,
    input  logic [7:0]        io_in,
    output logic [7:0]        io_out,
    output logic              io_oe,
    output logic              rdy,
    input  logic              pre_we,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic [PAGE_W-1:0] pre_page,
    input  logic [COL_W-1:0]  pre_col,
    input  logic [7:0]        pre_data
);
    localparam int NB    = 2**BANK_W;
    localparam int COLS  = 2**COL_W;
    localparam int CNT_W = $clog2(T_R + 1);
    localparam logic [CNT_W-1:0] TLAST = CNT_W'(T_R - 1);

    typedef struct packed {
        seq_st_e                      st;
        logic [1:0]                   acnt;
        logic [COL_W-1:0]             col;
        logic [PAGE_W-1:0]            pg;
        logic [BANK_W-1:0]            bk;
        logic [NB-1:0]                pend;
        logic [NB-1:0][PAGE_W-1:0]    ppage;
        logic [CNT_W-1:0]             tcnt;
        logic [BANK_W-1:0]            rbank;
        logic [COL_W-1:0]             rcol;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic we_hit, re_hit, cmd_hit, addr_hit;
    logic [NB-1:0] load_v;
    logic [NB*COLS*8-1:0] arr_rows;
    logic [7:0] reg_byte;

    mbr_strobe u_we_edge (.clk(clk), .rst_n(rst_n), .strb_n(we_n), .rise(we_hit));
    mbr_strobe u_re_edge (.clk(clk), .rst_n(rst_n), .strb_n(re_n), .rise(re_hit));

    assign cmd_hit  = we_hit & cle & ~ale;
    assign addr_hit = we_hit & ale & ~cle;

    mbr_array #(.BANK_W(BANK_W), .PAGE_W(PAGE_W), .COL_W(COL_W)) u_array (
        .clk      (clk),
        .pre_we   (pre_we),
        .pre_bank (pre_bank),
        .pre_page (pre_page),
        .pre_col  (pre_col),
        .pre_data (pre_data),
        .sel_page (ctl_q.ppage),
        .rows     (arr_rows)
    );

    mbr_bank_regs #(.BANK_W(BANK_W), .COL_W(COL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_v),
        .rows    (arr_rows),
        .rd_bank (ctl_q.rbank),
        .rd_col  (ctl_q.rcol),
        .rd_byte (reg_byte)
    );

    always_comb begin
        ctl_d  = ctl_q;
        load_v = '0;
        if (ctl_q.st == ST_XFER) begin
            // strobes are not looked at while the copy runs
            if (ctl_q.tcnt == TLAST) begin
                load_v     = ctl_q.pend;
                ctl_d.pend = '0;
                ctl_d.tcnt = '0;
                ctl_d.st   = ST_IDLE;
            end else begin
                ctl_d.tcnt = ctl_q.tcnt + 1'b1;
            end
        end else if (cmd_hit) begin
            // a command outranks a read strobe edge in the same cycle
            ctl_d.acnt = '0;
            if (ctl_q.st == ST_RDARM && io_in == OP_GO) begin
                ctl_d.st    = ST_STREAM;
                ctl_d.rbank = ctl_q.bk;
                ctl_d.rcol  = ctl_q.col;
            end else if (ctl_q.st == ST_IDLE || ctl_q.st == ST_STREAM) begin
                case (io_in)
                    OP_PAGE:  ctl_d.st = ST_PGSEL;
                    OP_PICK:  ctl_d.st = ST_RDSEL;
                    OP_START: ctl_d.st = (|ctl_q.pend) ? ST_XFER : ST_IDLE;
                    default:  ctl_d.st = ST_IDLE;
                endcase
            end else begin
                ctl_d.st = ST_IDLE;
            end
        end else if (addr_hit) begin
            if (ctl_q.st == ST_PGSEL || ctl_q.st == ST_RDSEL) begin
                case (ctl_q.acnt)
                    2'd0:    ctl_d.col = io_in[COL_W-1:0];
                    2'd1:    ctl_d.pg  = io_in[PAGE_W-1:0];
                    2'd2:    ctl_d.bk  = io_in[BANK_W-1:0];
                    default: ;
                endcase
                ctl_d.acnt = ctl_q.acnt + 1'b1;
                if (ctl_q.acnt == 2'd3) begin
                    if (ctl_q.st == ST_PGSEL) begin
                        ctl_d.pend[ctl_q.bk]  = 1'b1;
                        ctl_d.ppage[ctl_q.bk] = ctl_q.pg;
                        ctl_d.st              = ST_IDLE;
                    end else begin
                        ctl_d.st = ST_RDARM;
                    end
                end
            end else begin
                ctl_d.st = ST_IDLE;
            end
        end else if (re_hit && ctl_q.st == ST_STREAM) begin
            ctl_d.rcol = ctl_q.rcol + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rdy    = (ctl_q.st != ST_XFER);
    assign io_oe  = (ctl_q.st == ST_STREAM) && !re_n;
    assign io_out = (ctl_q.st == ST_STREAM) ? reg_byte : 8'h00;
endmodule

// File: rtl/mbr_check.sv
`timescale 1ns/1ps
module mbr_check #(
    parameter int T_R = 20
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic [7:0] io_in,
    input logic [7:0] io_out,
    input logic       io_oe,
    input logic       rdy
);
    localparam int CW = $clog2(T_R + 2);
    logic [CW-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n || rdy) busy_run <= '0;
        else               busy_run <= busy_run + 1'b1;
    end

    AST_BUSY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (busy_run < CW'(T_R)));  // R3

    AST_BUSY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> ($past(we_n && cle && !ale && io_in == 8'h31) && !$past(we_n, 2)));  // R3

    AST_OE_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        io_oe |-> !re_n);  // R7

    AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (!io_oe && io_out == 8'h00));  // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (io_out != $past(io_out)) |->
            (($past(re_n) != $past(re_n, 2)) || ($past(we_n) != $past(we_n, 2))));  // R8
endmodule

bind mbank_read_seq mbr_check #(.T_R(T_R)) u_mbr_check (
    .clk    (clk),
    .rst_n  (rst_n),
    .cle    (cle),
    .ale    (ale),
    .we_n   (we_n),
    .re_n   (re_n),
    .io_in  (io_in),
    .io_out (io_out),
    .io_oe  (io_oe),
    .rdy    (rdy)
);

// File: tb/mbank_read_seq_bench.sv
`timescale 1ns/1ps
module mbank_read_seq_bench;
    localparam int BANK_W = 2;
    localparam int PAGE_W = 2;
    localparam int COL_W  = 3;
    localparam int T_R    = 20;
    localparam int NB     = 4;
    localparam int PAGES  = 4;
    localparam int COLS   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic io_oe, rdy;
    logic pre_we = 1'b0;
    logic [BANK_W-1:0] pre_bank = '0;
    logic [PAGE_W-1:0] pre_page = '0;
    logic [COL_W-1:0]  pre_col = '0;
    logic [7:0]        pre_data = '0;

    always #2 clk = ~clk;

    mbank_read_seq #(.BANK_W(BANK_W), .PAGE_W(PAGE_W), .COL_W(COL_W), .T_R(T_R)) u_mbank_read_seq (
        .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rdy(rdy),
        .pre_we(pre_we), .pre_bank(pre_bank), .pre_page(pre_page),
        .pre_col(pre_col), .pre_data(pre_data)
    );

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t sb[$];
    int nchk = 0, nfail = 0;
    bit done = 1'b0;
    logic [7:0] regm [NB][COLS];
    int pendm [NB];
    int cur_b = 0, cur_c = 0;

    function automatic logic [7:0] pat(int b, int p, int c);
        return 8'((b*37 + p*11 + c*3 + 5) & 255);
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    // monitor: pops one expected byte on each start of output drive
    initial begin
        logic oe_prev;
        oe_prev = 1'b0;
        forever begin
            @(negedge clk); #1;
            if (io_oe && !oe_prev) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected output byte", io_out, -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(io_out === e.val, e.tag, "read byte", io_out, e.val);
                end
            end
            oe_prev = io_oe;
        end
    end

    task automatic put(bit c, bit a, logic [7:0] v);
        @(negedge clk); cle = c; ale = a; io_in = v; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0; ale = 1'b0;
        @(negedge clk);
    endtask

    task automatic pick_page(int b, int p);
        put(1, 0, 8'h00);
        put(0, 1, 8'h05);
        put(0, 1, 8'(p) | 8'hF0);
        put(0, 1, 8'(b) | 8'hA8);
        put(0, 1, 8'hFF);
        pendm[b] = p;
    endtask

    task automatic apply_copy();
        for (int b = 0; b < NB; b++) begin
            if (pendm[b] >= 0) begin
                for (int c = 0; c < COLS; c++) regm[b][c] = pat(b, pendm[b], c);
                pendm[b] = -1;
            end
        end
    endtask

    task automatic start_xfer(string tag);
        int n;
        bit any;
        any = 1'b0;
        for (int b = 0; b < NB; b++) if (pendm[b] >= 0) any = 1'b1;
        n = 0;
        @(negedge clk); cle = 1'b1; io_in = 8'h31; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        for (int i = 0; i < T_R + 8; i++) begin
            @(negedge clk); #1;
            if (!rdy) n++;
        end
        cle = 1'b0;
        check(n == (any ? T_R : 0), tag, "busy cycles", n, any ? T_R : 0);
        apply_copy();
    endtask

    task automatic choose(int b, int c);
        put(1, 0, 8'h06);
        put(0, 1, 8'(c));
        put(0, 1, 8'h00);
        put(0, 1, 8'(b));
        put(0, 1, 8'h00);
        put(1, 0, 8'hE0);
        cur_b = b; cur_c = c;
    endtask

    task automatic pull(int n, string tag);
        for (int i = 0; i < n; i++) begin
            sb.push_back('{regm[cur_b][cur_c], tag});
            @(negedge clk); re_n = 1'b0;
            @(negedge clk);
            @(negedge clk); re_n = 1'b1;
            @(negedge clk);
            cur_c = (cur_c + 1) % COLS;
        end
        check(sb.size() == 0, tag, "scoreboard drained", sb.size(), 0);
    endtask

    task automatic dead_pulse(string tag);
        @(negedge clk); re_n = 1'b0;
        @(negedge clk); #1;
        check(io_oe == 1'b0, tag, "no drive on read pulse", io_oe, 0);
        @(negedge clk); re_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            pendm[b] = -1;
            for (int c = 0; c < COLS; c++) regm[b][c] = 8'h00;
        end
        repeat (5) @(negedge clk);
        #1;
        check(rdy == 1'b1, "R1", "rdy in reset", rdy, 1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(rdy == 1'b1 && io_oe == 1'b0, "R1", "idle after reset", {rdy, io_oe}, 2);
        check(io_out == 8'h00, "R1", "io_out after reset", io_out, 0);

        for (int b = 0; b < NB; b++)
            for (int p = 0; p < PAGES; p++)
                for (int c = 0; c < COLS; c++) begin
                    @(negedge clk);
                    pre_we = 1'b1; pre_bank = BANK_W'(b); pre_page = PAGE_W'(p);
                    pre_col = COL_W'(c); pre_data = pat(b, p, c);
                end
        @(negedge clk); pre_we = 1'b0;

        // R2 R5: queue in mixed order, bank 0 twice
        pick_page(2, 1);
        pick_page(0, 3);
        pick_page(3, 0);
        pick_page(0, 2);
        start_xfer("R3");

        choose(0, 5); pull(10, "R5");   // wraps past column 7 (R8)
        choose(2, 0); pull(3, "R4");
        choose(3, 7); pull(2, "R8");
        choose(0, 5); pull(3, "R9");
        choose(1, 2); pull(2, "R6");    // never loaded: reset contents

        // R6: only bank 1 loaded, bank 2 keeps page 1
        pick_page(1, 2);
        start_xfer("R3");
        choose(2, 4); pull(2, "R6");
        choose(1, 0); pull(4, "R4");

        // R10: E0h with no selection
        put(1, 0, 8'hE0);
        dead_pulse("R10");
        put(1, 0, 8'hE0);
        dead_pulse("R10");

        // R10: start with empty queue
        start_xfer("R10");

        // R10: strobes during busy are dropped
        pick_page(3, 2);
        @(negedge clk); cle = 1'b1; io_in = 8'h31; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); cle = 1'b0;
        put(1, 0, 8'h00);
        put(0, 1, 8'h00);
        put(0, 1, 8'h01);
        begin
            int w;
            w = 0;
            while (!rdy && w < 100) begin @(negedge clk); w++; end
        end
        #1;
        check(rdy == 1'b1, "R10", "ready after busy", rdy, 1);
        apply_copy();
        put(0, 1, 8'h03);
        put(0, 1, 8'hFF);
        start_xfer("R10");
        choose(3, 0); pull(3, "R10");

        // R11: command cuts a page selection short
        put(1, 0, 8'h00);
        put(0, 1, 8'h00);
        put(0, 1, 8'h01);
        put(1, 0, 8'h06);
        start_xfer("R11");
        choose(2, 1); pull(2, "R11");

        // R12: command and read edge together
        choose(0, 1);
        sb.push_back('{regm[0][1], "R12"});
        @(negedge clk); cle = 1'b1; io_in = 8'h00; we_n = 1'b0; re_n = 1'b0;
        @(negedge clk);
        @(negedge clk); we_n = 1'b1; re_n = 1'b1;
        @(negedge clk); cle = 1'b0;
        @(negedge clk);
        check(sb.size() == 0, "R12", "byte before overlap", sb.size(), 0);
        dead_pulse("R12");
        put(0, 1, 8'h00);
        put(0, 1, 8'h01);
        put(0, 1, 8'h00);
        put(0, 1, 8'h00);
        pendm[0] = 1;
        start_xfer("R12");
        choose(0, 6); pull(3, "R12");

        repeat (4) @(negedge clk);
        report();
    end
endmodule